// File: doc/BRIEF.md
# GPIB Undefined Command Pass-Through

This block sits beside the command decoder of an IEEE-488 interface. Some command bytes arrive while ATN is true and the interface does not recognise them. When pass-through is enabled, the block copies such a byte into an 8-bit register that the processor can read. It then raises an interrupt flag and holds off the bus handshake until software has dealt with the byte.

Software releases the handshake in two steps. It reads the register, which clears the interrupt flag. It also issues the valid-command acknowledge. Either step may come first, and the hold drops only when both have happened.

An undefined primary opens a run of undefined secondary commands, and each one is captured and acknowledged in the same way. In the third addressing mode, the secondary byte that follows a matched primary address is also routed into the register, but it raises a separate address interrupt flag.

Top module: `gpib_cmd_passthru`

## Requirements
- R1: After reset, `cpt_reg` is 0x00, and `cpt_irq`, `apt_irq` and `hold` are all 0.
- R2: The block classifies each ATN-true byte by bits 6:5. If those bits are 11, the byte is a secondary (0x60 to 0x7F). Any other value makes it a primary (0x00 to 0x5F). Bit 7 is ignored for classification.
- R3: A primary with `atn`=1, `pt_enable`=1 and `cmd_known`=0 that arrives while `hold`=0 is stored unchanged in `cpt_reg`. The edge that samples `cmd_valid` also sets `cpt_irq`=1, keeps `apt_irq`=0 and sets `hold`=1.
- R4: With `pt_enable`=0, or with `cmd_known`=1, a primary that is not an address match leaves `cpt_reg` unchanged and leaves `hold` at 0.
- R5: `hold` falls only after both a `rd_strobe` and a `vscmd_strobe` have been seen since the capture, in either order. Either strobe on its own keeps `hold` at 1.
- R6: A `rd_strobe` while `hold`=1 clears `cpt_irq` and `apt_irq` on the next edge.
- R7: While `hold`=1, every command strobe is ignored, and `cpt_reg` stays unchanged.
- R8: After an undefined primary, up to 32 consecutive secondaries are each captured with `cpt_irq`. The 33rd secondary is ignored.
- R9: A secondary is ignored when it follows neither an undefined primary nor, in mode 3, a matched primary. A byte strobed with `atn`=0 is also ignored.
- R10: When `mode3`=1, a primary with `addr_hit`=1 is not captured. The next secondary is captured with `apt_irq`=1 and `cpt_irq`=0, and any secondary after that one is ignored. When `mode3`=0, the same sequence captures nothing.
- R11: While `atn`=0, any secondary run ends. A capture that is still pending keeps its data and `hold`. After ATN returns, a secondary is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe for a received bus byte |
| cmd_byte | input | 8 | Received byte |
| atn | input | 1 | ATN line state, 1 = command mode |
| cmd_known | input | 1 | The interface decodes this byte itself |
| addr_hit | input | 1 | This byte matches the device's own primary address |
| pt_enable | input | 1 | Pass-through enable |
| mode3 | input | 1 | Addressing mode 3 selected (secondary addresses passed to software) |
| rd_strobe | input | 1 | Processor read of the pass-through register |
| vscmd_strobe | input | 1 | Valid-command acknowledge from the processor |
| cpt_reg | output | 8 | Pass-through register contents |
| cpt_irq | output | 1 | Undefined command captured |
| apt_irq | output | 1 | Secondary address captured |
| hold | output | 1 | Bus handshake hold-off |

## Verification
The bench sends single undefined primaries and services each one twice over: once with the read before the acknowledge, and once the other way round. This tells a release that needs both events apart from one that fires on either. It then sends the same primary with the enable cleared, with the byte marked as decoded, and while a hold is pending, which separates real capture gating from a register that follows every strobe. A full run of 32 secondaries plus one extra checks that the run length is exact. Orphan secondaries, ATN-false bytes, the mode 3 address sequence and an ATN drop in the middle of a run check that only valid sequence context lets a secondary through.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    typedef enum logic [1:0] {
        RUN_IDLE  = 2'd0,
        RUN_UNDEF = 2'd1,
        RUN_ADDR  = 2'd2
    } run_e;

endpackage

// File: rtl/gpt_classify.sv
module gpt_classify (
    input  logic [1:0] hi_bits,
    output logic       is_pri,
    output logic       is_sec
);
    localparam logic [1:0] SEC_TAG = 2'b11;

    always_comb begin
        is_sec = (hi_bits == SEC_TAG);
        is_pri = !is_sec;
    end
endmodule

// File: rtl/gpt_sequencer.sv
module gpt_sequencer #(
    parameter int MAX_SEC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic atn,
    input  logic hold_q,
    input  logic is_pri,
    input  logic is_sec,
    input  logic cmd_known,
    input  logic addr_hit,
    input  logic pt_enable,
    input  logic mode3,
    output logic cap_cmd,
    output logic cap_sec
);
    import gpt_pkg::*;

    localparam int CW = $clog2(MAX_SEC + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_SEC - 1);

    typedef struct packed {
        run_e          st;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic accept;

    always_comb begin
        s_d     = s_q;
        cap_cmd = 1'b0;
        cap_sec = 1'b0;
        accept  = cmd_valid && atn && !hold_q;
        if (!atn) begin
            s_d.st  = RUN_IDLE;
            s_d.cnt = '0;
        end else if (accept) begin
            if (is_pri) begin
                s_d.cnt = '0;
                if (mode3 && addr_hit) begin
                    s_d.st = RUN_ADDR;
                end else if (pt_enable && !cmd_known) begin
                    cap_cmd = 1'b1;
                    s_d.st  = RUN_UNDEF;
                end else begin
                    s_d.st = RUN_IDLE;
                end
            end else if (is_sec) begin
                case (s_q.st)
                    RUN_UNDEF: begin
                        if (pt_enable) begin
                            cap_cmd = 1'b1;
                            s_d.cnt = s_q.cnt + 1'b1;
                            if (s_q.cnt == LAST) begin
                                s_d.st  = RUN_IDLE;
                                s_d.cnt = '0;
                            end
                        end else begin
                            s_d.st  = RUN_IDLE;
                            s_d.cnt = '0;
                        end
                    end
                    RUN_ADDR: begin
                        if (mode3) begin
                            cap_sec = 1'b1;
                        end
                        s_d.st = RUN_IDLE;
                    end
                    default: s_d.st = RUN_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st  <= RUN_IDLE;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/gpt_release.sv
module gpt_release #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_cmd,
    input  logic          cap_sec,
    input  logic [DW-1:0] cmd_byte,
    input  logic          rd_strobe,
    input  logic          vscmd_strobe,
    output logic [DW-1:0] data_q,
    output logic          cpt_q,
    output logic          apt_q,
    output logic          hold_q
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          cpt;
        logic          apt;
        logic          hold;
        logic          rd_seen;
        logic          ack_seen;
    } rel_t;

    rel_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cap_cmd || cap_sec) begin
            r_d.data     = cmd_byte;
            r_d.cpt      = cap_cmd;
            r_d.apt      = cap_sec;
            r_d.hold     = 1'b1;
            r_d.rd_seen  = 1'b0;
            r_d.ack_seen = 1'b0;
        end else if (r_q.hold) begin
            if (rd_strobe) begin
                r_d.rd_seen = 1'b1;
                r_d.cpt     = 1'b0;
                r_d.apt     = 1'b0;
            end
            if (vscmd_strobe) begin
                r_d.ack_seen = 1'b1;
            end
            if (r_d.rd_seen && r_d.ack_seen) begin
                r_d.hold     = 1'b0;
                r_d.rd_seen  = 1'b0;
                r_d.ack_seen = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_q = r_q.data;
    assign cpt_q  = r_q.cpt;
    assign apt_q  = r_q.apt;
    assign hold_q = r_q.hold;
endmodule

// File: rtl/gpib_cmd_passthru.sv
module gpib_cmd_passthru #(
    parameter int DW      = 8,
    parameter int MAX_SEC = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [DW-1:0] cmd_byte,
    input  logic          atn,
    input  logic          cmd_known,
    input  logic          addr_hit,
    input  logic          pt_enable,
    input  logic          mode3,
    input  logic          rd_strobe,
    input  logic          vscmd_strobe,
    output logic [DW-1:0] cpt_reg,
    output logic          cpt_irq,
    output logic          apt_irq,
    output logic          hold
);
    logic is_pri, is_sec, cap_cmd, cap_sec;

    gpt_classify i_cls (
        .hi_bits (cmd_byte[6:5]),
        .is_pri  (is_pri),
        .is_sec  (is_sec)
    );

    gpt_sequencer #(.MAX_SEC(MAX_SEC)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .atn       (atn),
        .hold_q    (hold),
        .is_pri    (is_pri),
        .is_sec    (is_sec),
        .cmd_known (cmd_known),
        .addr_hit  (addr_hit),
        .pt_enable (pt_enable),
        .mode3     (mode3),
        .cap_cmd   (cap_cmd),
        .cap_sec   (cap_sec)
    );

    gpt_release #(.DW(DW)) i_rel (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_cmd      (cap_cmd),
        .cap_sec      (cap_sec),
        .cmd_byte     (cmd_byte),
        .rd_strobe    (rd_strobe),
        .vscmd_strobe (vscmd_strobe),
        .data_q       (cpt_reg),
        .cpt_q        (cpt_irq),
        .apt_q        (apt_irq),
        .hold_q       (hold)
    );
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          atn,
    input logic          rd_strobe,
    input logic          vscmd_strobe,
    input logic [DW-1:0] cpt_reg,
    input logic          cpt_irq,
    input logic          apt_irq,
    input logic          hold
);
    // R3
    hold_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> $past(cmd_valid && atn));

    // R7
    reg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(cpt_reg));

    // R6
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && hold) |=> (!cpt_irq && !apt_irq));

    // R5
    release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> $past(rd_strobe || vscmd_strobe));

    // R10
    one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpt_irq, apt_irq}));

    // R5
    flag_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpt_irq || apt_irq) |-> hold);
endmodule

bind gpib_cmd_passthru gpt_checker #(.DW(DW)) i_gpt_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .atn          (atn),
    .rd_strobe    (rd_strobe),
    .vscmd_strobe (vscmd_strobe),
    .cpt_reg      (cpt_reg),
    .cpt_irq      (cpt_irq),
    .apt_irq      (apt_irq),
    .hold         (hold)
);

// File: tb/test_gpib_cmd_passthru.sv
module test_gpib_cmd_passthru;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       atn = 1'b1;
    logic       cmd_known = 1'b0;
    logic       addr_hit = 1'b0;
    logic       pt_enable = 1'b1;
    logic       mode3 = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       vscmd_strobe = 1'b0;
    logic [7:0] cpt_reg;
    logic       cpt_irq, apt_irq, hold;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpib_cmd_passthru i_gpib_cmd_passthru (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .atn(atn), .cmd_known(cmd_known), .addr_hit(addr_hit),
        .pt_enable(pt_enable), .mode3(mode3), .rd_strobe(rd_strobe),
        .vscmd_strobe(vscmd_strobe), .cpt_reg(cpt_reg), .cpt_irq(cpt_irq),
        .apt_irq(apt_irq), .hold(hold)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_state(input string req, input logic [7:0] r,
                                input bit c, input bit a, input bit h);
        chk(cpt_reg == r, req, "cpt_reg", cpt_reg, r);
        chk(cpt_irq == c, req, "cpt_irq", cpt_irq, c);
        chk(apt_irq == a, req, "apt_irq", apt_irq, a);
        chk(hold == h, req, "hold", hold, h);
    endtask

    // drive at a falling edge, sampled at the rising edge, observed at the next falling edge
    task automatic send(input logic [7:0] b, input bit known, input bit hit);
        cmd_byte = b; cmd_known = known; addr_hit = hit; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_known = 1'b0; addr_hit = 1'b0;
    endtask

    task automatic pulse_rd();
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic pulse_ack();
        vscmd_strobe = 1'b1; @(negedge clk); vscmd_strobe = 1'b0;
    endtask

    task automatic service();
        pulse_rd();
        pulse_ack();
    endtask

    task automatic t_reset();
        expect_state("R1", 8'h00, 0, 0, 0);
    endtask

    task automatic t_read_then_ack();
        send(8'h15, 0, 0);
        expect_state("R3", 8'h15, 1, 0, 1);
        pulse_rd();
        expect_state("R6", 8'h15, 0, 0, 1);
        pulse_ack();
        chk(hold == 0, "R5", "hold after read+ack", hold, 0);
    endtask

    task automatic t_ack_then_read();
        atn = 1'b0; @(negedge clk); atn = 1'b1;
        send(8'h9A, 0, 0);   // bit 7 set, still a primary (R2)
        expect_state("R2", 8'h9A, 1, 0, 1);
        pulse_ack();
        expect_state("R5", 8'h9A, 1, 0, 1);
        pulse_rd();
        expect_state("R5", 8'h9A, 0, 0, 0);
    endtask

    task automatic t_gating();
        atn = 1'b0; @(negedge clk); atn = 1'b1;
        pt_enable = 1'b0;
        send(8'h22, 0, 0);
        expect_state("R4", 8'h9A, 0, 0, 0);
        pt_enable = 1'b1;
        send(8'h3F, 1, 0);
        expect_state("R4", 8'h9A, 0, 0, 0);
    endtask

    task automatic t_hold_blocks();
        send(8'h05, 0, 0);
        send(8'h07, 0, 0);
        expect_state("R7", 8'h05, 1, 0, 1);
        service();
        chk(hold == 0, "R7", "hold released", hold, 0);
    endtask

    task automatic t_sec_run();
        atn = 1'b0; @(negedge clk); atn = 1'b1;
        send(8'h10, 0, 0);
        service();
        for (int i = 0; i < 32; i++) begin
            send(8'h60 + 8'(i), 0, 0);
            chk(cpt_reg == 8'h60 + 8'(i) && cpt_irq && hold, "R8",
                "secondary in run captured", cpt_reg, 8'h60 + i);
            service();
        end
        send(8'h61, 0, 0);
        expect_state("R8", 8'h7F, 0, 0, 0);
    endtask

    task automatic t_orphan();
        send(8'h65, 0, 0);
        expect_state("R9", 8'h7F, 0, 0, 0);
        atn = 1'b0;
        send(8'h12, 0, 0);
        atn = 1'b1;
        expect_state("R9", 8'h7F, 0, 0, 0);
    endtask

    task automatic t_mode3();
        mode3 = 1'b1;
        send(8'h25, 1, 1);
        expect_state("R10", 8'h7F, 0, 0, 0);
        send(8'h6C, 0, 0);
        expect_state("R10", 8'h6C, 0, 1, 1);
        service();
        send(8'h6D, 0, 0);
        expect_state("R10", 8'h6C, 0, 0, 0);
        mode3 = 1'b0;
        send(8'h25, 1, 1);
        send(8'h6E, 0, 0);
        expect_state("R10", 8'h6C, 0, 0, 0);
    endtask

    task automatic t_atn_drop();
        send(8'h11, 0, 0);
        atn = 1'b0;
        @(negedge clk);
        expect_state("R11", 8'h11, 1, 0, 1);
        service();
        atn = 1'b1;
        @(negedge clk);
        send(8'h62, 0, 0);
        expect_state("R11", 8'h11, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_then_ack();
        t_ack_then_read();
        t_gating();
        t_hold_blocks();
        t_sec_run();
        t_orphan();
        t_mode3();
        t_atn_drop();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule